// File: doc/BRIEF.md
# Self-Correcting Modulo-5 JK Counter

This block is a three-bit synchronous counter made of three JK flip-flop stages. While counting is enabled it steps through the values zero to four and then returns to zero. Each stage gets its J and K inputs from fixed combinational equations of the present state, not from an adder. The equations are chosen so that any of the three unused codes falls back to zero on the next enabled clock edge. A supply glitch or an upset flop therefore cannot trap the counter outside its cycle.

The count leaves the block as a three-bit word. The most significant bit is stage C and the least significant bit is stage A. A terminal-count flag marks the cycle in which an enabled edge will wrap the count back to zero, so several counters can be chained. An active-low asynchronous reset clears all three stages. A synchronous enable freezes the state by driving every J and K input low.

Top module: `mod5_jk_counter`

## Requirements
- R1: While `rst_n` is low, `count_o` is 3'b000 at once, with no clock edge needed, and `tc_o` is low.
- R2: With `en` high, each rising clock edge moves the count from 0 to 1, 1 to 2, 2 to 3, 3 to 4 and 4 to 0. `count_o` is read as an unsigned binary value, bit 2 most significant.
- R3: With `en` high, each unused code (3'b101, 3'b110 or 3'b111) becomes 3'b000 after one rising edge.
- R4: With `en` low, a rising edge leaves `count_o` unchanged. This includes the unused codes.
- R5: `tc_o` is high exactly when `count_o` is 3'b100 and `en` is high. After a cycle with `tc_o` high, the count is 3'b000.
- R6: Each stage behaves as a JK flip-flop: it holds when J=0 and K=0, clears when J=0 and K=1, sets when J=1 and K=0, and toggles when both are 1. At the ports this means that on every enabled edge, bit 0 inverts while bit 2 is 0 and clears while bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count enable; low forces all J and K inputs low |
| count_o | output | 3 | Current state, bit 2 = stage C, bit 0 = stage A |
| tc_o | output | 1 | Terminal count: state 3'b100 with enable high |

## Verification
Two behaviours can act on the same edge: recovery from an unused code and the hold imposed by a low enable. The gating wins, so an unused code with enable low stays where it is. To provoke this, the bench places each unused code in the stages right as reset is released. It then applies one edge with enable low and checks that the code persists. It then raises enable and checks that the code collapses to zero in one edge, with the terminal-count flag low throughout. Random enable and reset patterns are compared against an arithmetic model written in the bench.

// File: rtl/mod5_jk_pkg.sv
package mod5_jk_pkg;

  localparam int unsigned CNT_W     = 3;
  localparam int unsigned MODULUS   = 5;
  localparam logic [CNT_W-1:0] LAST_CODE = CNT_W'(MODULUS - 1);
  localparam logic [CNT_W-1:0] ZERO_CODE = '0;

  // Bit positions of the named stages inside the state word.
  localparam int unsigned BIT_A = 0;
  localparam int unsigned BIT_B = 1;
  localparam int unsigned BIT_C = 2;

  typedef enum logic [1:0] {
    JK_HOLD   = 2'b00,
    JK_CLEAR  = 2'b01,
    JK_SET    = 2'b10,
    JK_TOGGLE = 2'b11
  } jk_op_e;

  typedef struct packed {
    logic [CNT_W-1:0] j;
    logic [CNT_W-1:0] k;
  } jk_drive_t;

  // Next value of one JK stage.
  function automatic logic jk_apply(input logic q, input logic j, input logic k);
    jk_op_e op;
    op = jk_op_e'({j, k});
    unique case (op)
      JK_HOLD:   return q;
      JK_CLEAR:  return 1'b0;
      JK_SET:    return 1'b1;
      default:   return ~q;
    endcase
  endfunction

  // Ungated excitation equations for the modulo-5 sequence.
  function automatic jk_drive_t excite(input logic [CNT_W-1:0] s);
    jk_drive_t d;
    logic a, b, c;
    a = s[BIT_A];
    b = s[BIT_B];
    c = s[BIT_C];
    d.j[BIT_A] = ~c;
    d.k[BIT_A] = 1'b1;
    d.j[BIT_B] = ~c & a;
    d.k[BIT_B] = c | a;
    d.j[BIT_C] = b & a;
    d.k[BIT_C] = 1'b1;
    return d;
  endfunction

  function automatic logic is_unused(input logic [CNT_W-1:0] s);
    return s > LAST_CODE;
  endfunction

endpackage

// File: rtl/mod5_jk_stage.sv
module mod5_jk_stage #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic j,
  input  logic k,
  output logic q
);

  logic q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= RST_VAL;
    end else begin
      q_r <= mod5_jk_pkg::jk_apply(q_r, j, k);
    end
  end

  assign q = q_r;

endmodule

// File: rtl/mod5_jk_excite.sv
module mod5_jk_excite
  import mod5_jk_pkg::*;
(
  input  logic [CNT_W-1:0] state_i,
  input  logic             en,
  output logic [CNT_W-1:0] j_o,
  output logic [CNT_W-1:0] k_o
);

  jk_drive_t raw_w;

  assign raw_w = excite(state_i);

  // The enable gates every input to the hold code.
  for (genvar i = 0; i < CNT_W; i++) begin : g_gate
    assign j_o[i] = en & raw_w.j[i];
    assign k_o[i] = en & raw_w.k[i];
  end

endmodule

// File: rtl/mod5_jk_counter.sv
module mod5_jk_counter
  import mod5_jk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);

  logic [CNT_W-1:0] state_w;
  logic [CNT_W-1:0] j_w;
  logic [CNT_W-1:0] k_w;

  // Named events, brought out for the checker.
  logic unused_w;
  logic last_w;

  mod5_jk_excite u_excite (
    .state_i (state_w),
    .en      (en),
    .j_o     (j_w),
    .k_o     (k_w)
  );

  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    mod5_jk_stage #(
      .RST_VAL (ZERO_CODE[i])
    ) u_ff (
      .clk   (clk),
      .rst_n (rst_n),
      .j     (j_w[i]),
      .k     (k_w[i]),
      .q     (state_w[i])
    );
  end

  assign unused_w = is_unused(state_w);
  assign last_w   = (state_w == LAST_CODE);

  assign count_o = state_w;
  assign tc_o    = last_w & en;

endmodule

// File: rtl/mod5_jk_counter_chk.sv
module mod5_jk_counter_chk
  import mod5_jk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CNT_W-1:0] count,
  input logic             tc,
  input logic [CNT_W-1:0] j_vec,
  input logic [CNT_W-1:0] k_vec,
  input logic             unused
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (count == ZERO_CODE) && !tc);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && (count < LAST_CODE) |=> count == $past(count) + 1'b1);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && (count == LAST_CODE) |=> count == ZERO_CODE);

  p_recover_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en && unused |=> count == ZERO_CODE);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  p_tc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> count == ZERO_CODE);

  for (genvar i = 0; i < CNT_W; i++) begin : g_stage_chk
    p_jk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !j_vec[i] && !k_vec[i] |=> $stable(count[i]));
    p_jk_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !j_vec[i] && k_vec[i] |=> !count[i]);
    p_jk_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      j_vec[i] && !k_vec[i] |=> count[i]);
    p_jk_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      j_vec[i] && k_vec[i] |=> count[i] != $past(count[i]));
  end

endmodule

bind mod5_jk_counter mod5_jk_counter_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .count  (count_o),
  .tc     (tc_o),
  .j_vec  (j_w),
  .k_vec  (k_w),
  .unused (unused_w)
);

// File: tb/mod5_jk_counter_tb.sv
module mod5_jk_counter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 400;
  localparam int WATCHDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [2:0] count_o;
  logic       tc_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  int expv     = 0;

  mod5_jk_counter u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .count_o (count_o),
    .tc_o    (tc_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Arithmetic model of the sequence (R2, R3, R4).
  function automatic int model_next(input int c, input bit e);
    if (!e) return c;
    if (c >= 4) return 0;
    return c + 1;
  endfunction

  function automatic bit model_tc(input int c, input bit e);
    return e && (c == 4);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
    end
  endtask

  // Called at a falling edge; leaves at the next falling edge.
  task automatic step(input bit e, input bit r, input string req);
    bit a_exp;
    en    = e;
    rst_n = r;
    if (!r) expv = 0;
    #1;
    check(count_o == 3'(expv), req, count_o, expv);
    check(tc_o == model_tc(expv, e), "R5", tc_o, model_tc(expv, e));
    // R6: stage A inverts while C is 0 and clears while C is 1.
    a_exp = (e && r) ? ((expv >= 4) ? 1'b0 : ~expv[0]) : (r ? expv[0] : 1'b0);
    @(posedge clk);
    if (r) expv = model_next(expv, e);
    @(negedge clk);
    check(count_o[0] == a_exp, "R6", count_o[0], a_exp);
  endtask

  // Places an unused code in the stages as reset is released.
  task automatic plant(input logic [2:0] v);
    rst_n = 1'b0;
    en    = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    force u_dut.g_stage[0].u_ff.q_r = v[0];
    force u_dut.g_stage[1].u_ff.q_r = v[1];
    force u_dut.g_stage[2].u_ff.q_r = v[2];
    #1;
    release u_dut.g_stage[0].u_ff.q_r;
    release u_dut.g_stage[1].u_ff.q_r;
    release u_dut.g_stage[2].u_ff.q_r;
    #1;
    expv = int'(v);
    check(count_o == v, "R3 setup", count_o, v);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    void'($urandom(32'h0C0FFEE5));
    repeat (3) @(negedge clk);
    #1;
    check(count_o == 3'b000, "R1", count_o, 0);
    check(tc_o == 1'b0, "R1", tc_o, 0);
    @(negedge clk);

    // Full sequence with wrap, twice round.
    for (int i = 0; i < 11; i++) step(1'b1, 1'b1, "R2");

    // Hold at 2 and at 4 with enable low.
    while (expv != 2) step(1'b1, 1'b1, "R2");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R4");
    while (expv != 4) step(1'b1, 1'b1, "R2");
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, "R4");
    step(1'b1, 1'b1, "R5 wrap");
    check(count_o == 3'b000, "R5", count_o, 0);

    // Asynchronous reset between edges.
    while (expv != 3) step(1'b1, 1'b1, "R2");
    #2;
    rst_n = 1'b0;
    #1;
    check(count_o == 3'b000, "R1 async", count_o, 0);
    expv = 0;
    @(negedge clk);
    step(1'b1, 1'b1, "R1");

    // Unused codes: hold with enable low, then recover.
    for (int c = 5; c < 8; c++) begin
      plant(3'(c));
      step(1'b0, 1'b1, "R4 unused hold");
      step(1'b1, 1'b1, "R3 recover");
      check(count_o == 3'b000, "R3", count_o, 0);
    end

    // Constrained random enable and reset.
    for (int i = 0; i < RAND_CYCLES; i++) begin
      bit e;
      bit r;
      e = ($urandom % 4) != 0;
      r = ($urandom % 50) != 0;
      step(e, r, "R2/R4 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule